// File: doc/BRIEF.md
# UART Line Mode Controller

This block sits between a UART transmitter, a UART receiver and the two serial pins. It decides which signal goes to each of them. A CPU write port loads an 8-bit control word. From that word the block takes the line mode, a receiver gate, the two modem control outputs and two interrupt enables. It presents the enables to the rest of the UART and drives the pins. The transmitter and the receiver appear here only as single-bit ports: the transmitter's serial output and a run permission sent back to the transmitter. The baud clock, shift registers and parity logic are outside this block.

The line mode is held in a four-state machine whose state register changes only on a CPU write. There are four states, and each one fixes the routing:

- `LM_NORMAL`: the transmitter drives the output pin and the input pin feeds the receiver.
- `LM_BREAK`: the output pin is held at space (0).
- `LM_ECHO`: the input pin is copied to the output pin through a purely combinational path, and the transmitter is told not to send.
- `LM_LOOP`: transmit data goes internally to the receiver, and the output pin idles at mark (1).

There is one transition rule, named *load-mode*. Every write takes the machine from any state to the state encoded in the written mode field. With no write, the machine stays in its present state; this is the *hold* transition.

Top module: `uart_line_mode_ctrl`

## Requirements
- R1: After reset the control word is 0x00. The mode is normal, `rts_n` and `dtr_n` are 1, `irq_en`, `modem_irq_en` and the receiver gate are 0, and `rx_serial` is 1.
- R2: A write (`wr_en`=1) takes effect at the rising clock edge where it is sampled. Outputs show the old word before that edge and the new word after it.
- R3: Control word bits [1:0] select the mode, and 00 selects normal mode. In normal mode `sdo_pin` equals `tx_serial`. When the receiver is enabled, `rx_serial` equals `sdi_pin`.
- R4: Mode field 01 selects break. In break mode `sdo_pin` is 0 for as long as the mode is held, and `tx_run` stays 1.
- R5: Mode field 10 selects echo. In echo mode `sdo_pin` follows `sdi_pin` combinationally within the same cycle, and `tx_run` is 0. In every other mode `tx_run` is 1.
- R6: Mode field 11 selects loop test. In loop mode `sdo_pin` is 1, and `rx_serial` equals `tx_serial` when the receiver is enabled.
- R7: Bit 2 is the receiver enable. When it is 0, `rx_serial` is 1 in every mode, whatever the values of `sdi_pin` and `tx_serial`.
- R8: Bit 3 controls RTS and bit 4 controls DTR, both with inverted sense: `rts_n` = NOT bit 3 and `dtr_n` = NOT bit 4.
- R9: Bit 5 appears on `irq_en` and bit 6 appears on `modem_irq_en`.
- R10: Bit 7 is reserved. Writing it as 1 gives exactly the same outputs as writing it as 0.
- R11: While `wr_en` is 0, the mode and all control outputs keep their values, whatever is on `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word to load |
| tx_serial | input | 1 | Serial data from the transmitter |
| sdi_pin | input | 1 | Serial input pin |
| sdo_pin | output | 1 | Serial output pin |
| rx_serial | output | 1 | Serial data into the receiver |
| tx_run | output | 1 | Permission for the transmitter to send |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| irq_en | output | 1 | Interrupt master enable |
| modem_irq_en | output | 1 | Modem-status interrupt enable |

## Verification
The bench writes all 256 control words. For each word it drives all four combinations of pin input and transmit data, and compares every output against values worked out from the bit fields. That sweep targets the following faults:

- A mode decoder with two codes swapped shows a stuck space or mark where data should pass.
- An echo path that sends transmit data instead of the input pin gives a wrong bit in half of the combinations.
- A loop mode that leaks data onto the output pin shows up as a non-idle output.
- A receiver gate that is missing, or that idles at 0, presents false start bits.

Separate checks cover the remaining faults:

- A reserved bit that leaks into a field shows up in the upper half of the sweep.
- RTS or DTR with the wrong polarity is caught on the modem pins.
- A write that lands a cycle late, or that is taken without the strobe, is caught by checks placed on each side of the write edge and during held cycles with garbage on the data bus.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

    localparam int CTRL_W   = 8;
    localparam int MODE_LSB = 0;
    localparam int MODE_W   = 2;
    localparam int RXEN_BIT = 2;
    localparam int RTS_BIT  = 3;
    localparam int DTR_BIT  = 4;
    localparam int IRQ_BIT  = 5;
    localparam int MIRQ_BIT = 6;
    localparam int RSVD_BIT = 7;

    typedef enum logic [MODE_W-1:0] {
        LM_NORMAL = 2'b00,
        LM_BREAK  = 2'b01,
        LM_ECHO   = 2'b10,
        LM_LOOP   = 2'b11
    } line_mode_e;

    typedef enum logic [1:0] {
        SDO_TX    = 2'b00,
        SDO_SPACE = 2'b01,
        SDO_PIN   = 2'b10,
        SDO_MARK  = 2'b11
    } sdo_src_e;

    typedef struct packed {
        logic mirq_en;
        logic irq_en;
        logic dtr;
        logic rts;
        logic rx_en;
    } ctrl_flags_t;

endpackage

// File: rtl/lmc_ctrl_reg.sv
module lmc_ctrl_reg
    import lmc_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output ctrl_flags_t  flags
);

    ctrl_flags_t flags_q;

    // Mode bits belong to the state machine; the reserved bit is dropped.
    logic unused_fields;
    assign unused_fields = ^{wr_data[MODE_LSB +: MODE_W], wr_data[RSVD_BIT]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (wr_en) begin
            flags_q.rx_en   <= wr_data[RXEN_BIT];
            flags_q.rts     <= wr_data[RTS_BIT];
            flags_q.dtr     <= wr_data[DTR_BIT];
            flags_q.irq_en  <= wr_data[IRQ_BIT];
            flags_q.mirq_en <= wr_data[MIRQ_BIT];
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/lmc_mode_fsm.sv
module lmc_mode_fsm
    import lmc_pkg::*;
#(
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [MW-1:0] mode_wr,
    output line_mode_e    state,
    output sdo_src_e      sdo_src,
    output logic          rx_from_tx,
    output logic          tx_run
);

    line_mode_e state_q;
    line_mode_e state_d;

    // Next state: load-mode on a write, hold otherwise.
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (mode_wr)
                2'b00:   state_d = LM_NORMAL;
                2'b01:   state_d = LM_BREAK;
                2'b10:   state_d = LM_ECHO;
                default: state_d = LM_LOOP;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LM_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    // Per-state routing outputs
    always_comb begin
        sdo_src    = SDO_TX;
        rx_from_tx = 1'b0;
        tx_run     = 1'b1;
        unique case (state_q)
            LM_NORMAL: begin
                sdo_src    = SDO_TX;
                rx_from_tx = 1'b0;
                tx_run     = 1'b1;
            end
            LM_BREAK: begin
                sdo_src    = SDO_SPACE;
                rx_from_tx = 1'b0;
                tx_run     = 1'b1;
            end
            LM_ECHO: begin
                sdo_src    = SDO_PIN;
                rx_from_tx = 1'b0;
                tx_run     = 1'b0;
            end
            LM_LOOP: begin
                sdo_src    = SDO_MARK;
                rx_from_tx = 1'b1;
                tx_run     = 1'b1;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/lmc_route.sv
module lmc_route
    import lmc_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  sdo_src_e sdo_src,
    input  logic     rx_from_tx,
    input  logic     rx_en,
    input  logic     tx_serial,
    input  logic     sdi_pin,
    output logic     sdo_pin,
    output logic     rx_serial
);

    logic rx_src;

    always_comb begin
        unique case (sdo_src)
            SDO_TX:    sdo_pin = tx_serial;
            SDO_SPACE: sdo_pin = ~IDLE_LEVEL;
            SDO_PIN:   sdo_pin = sdi_pin;
            SDO_MARK:  sdo_pin = IDLE_LEVEL;
        endcase
    end

    assign rx_src    = rx_from_tx ? tx_serial : sdi_pin;
    assign rx_serial = rx_en ? rx_src : IDLE_LEVEL;

endmodule

// File: rtl/lmc_modem_out.sv
module lmc_modem_out #(
    parameter int N          = 2,
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic [N-1:0] ctl,
    output logic [N-1:0] pins
);

    generate
        if (ACTIVE_LOW) begin : g_inv
            assign pins = ~ctl;
        end else begin : g_pass
            assign pins = ctl;
        end
    endgenerate

endmodule

// File: rtl/uart_line_mode_ctrl.sv
module uart_line_mode_ctrl
    import lmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              tx_serial,
    input  logic              sdi_pin,
    output logic              sdo_pin,
    output logic              rx_serial,
    output logic              tx_run,
    output logic              rts_n,
    output logic              dtr_n,
    output logic              irq_en,
    output logic              modem_irq_en
);

    ctrl_flags_t flags;
    line_mode_e  cur_mode;
    sdo_src_e    sdo_src;
    logic        rx_from_tx;
    logic [1:0]  modem_pins;

    lmc_ctrl_reg #(.W(CTRL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .flags   (flags)
    );

    lmc_mode_fsm #(.MW(MODE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .mode_wr    (wr_data[MODE_LSB +: MODE_W]),
        .state      (cur_mode),
        .sdo_src    (sdo_src),
        .rx_from_tx (rx_from_tx),
        .tx_run     (tx_run)
    );

    lmc_route #(.IDLE_LEVEL(1'b1)) u_route (
        .sdo_src    (sdo_src),
        .rx_from_tx (rx_from_tx),
        .rx_en      (flags.rx_en),
        .tx_serial  (tx_serial),
        .sdi_pin    (sdi_pin),
        .sdo_pin    (sdo_pin),
        .rx_serial  (rx_serial)
    );

    lmc_modem_out #(.N(2), .ACTIVE_LOW(1'b1)) u_modem (
        .ctl  ({flags.dtr, flags.rts}),
        .pins (modem_pins)
    );

    assign rts_n        = modem_pins[0];
    assign dtr_n        = modem_pins[1];
    assign irq_en       = flags.irq_en;
    assign modem_irq_en = flags.mirq_en;

endmodule

// File: rtl/lmc_checker.sv
module lmc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] mode,
    input logic       rx_en,
    input logic       sdi_pin,
    input logic       tx_serial,
    input logic       sdo_pin,
    input logic       rx_serial,
    input logic       tx_run
);

    AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (sdo_pin == tx_serial)); // R3

    AST_BREAK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> (sdo_pin == 1'b0 && tx_run)); // R4

    AST_ECHO_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> (sdo_pin == sdi_pin && !tx_run)); // R5

    AST_LOOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> (sdo_pin == 1'b1)); // R6

    AST_LOOP_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && rx_en) |-> (rx_serial == tx_serial)); // R6

    AST_RX_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> rx_serial); // R7

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode)); // R11

endmodule

bind uart_line_mode_ctrl lmc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .mode      (cur_mode),
    .rx_en     (flags.rx_en),
    .sdi_pin   (sdi_pin),
    .tx_serial (tx_serial),
    .sdo_pin   (sdo_pin),
    .rx_serial (rx_serial),
    .tx_run    (tx_run)
);

// File: tb/uart_line_mode_ctrl_test.sv
module uart_line_mode_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_serial = 1'b0;
    logic       sdi_pin = 1'b0;
    logic       sdo_pin, rx_serial, tx_run, rts_n, dtr_n, irq_en, modem_irq_en;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    uart_line_mode_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .tx_serial    (tx_serial),
        .sdi_pin      (sdi_pin),
        .sdo_pin      (sdo_pin),
        .rx_serial    (rx_serial),
        .tx_run       (tx_run),
        .rts_n        (rts_n),
        .dtr_n        (dtr_n),
        .irq_en       (irq_en),
        .modem_irq_en (modem_irq_en)
    );

    task automatic check(input string req, input string what, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Drive all four input combinations within the low clock phase and
    // compare against values derived from the control word fields.
    task automatic check_word(input logic [7:0] v);
        logic [1:0] m;
        logic       rxen, e_sdo, e_rx;
        string      t_sdo, t_rx, sfx;
        m    = v[1:0];
        rxen = v[2];
        sfx  = v[7] ? " rsvd=1 R10" : "";
        for (int c = 0; c < 4; c++) begin
            sdi_pin   = c[0];
            tx_serial = c[1];
            #1;
            unique case (m)
                2'b00: begin e_sdo = tx_serial; t_sdo = "R3"; end
                2'b01: begin e_sdo = 1'b0;      t_sdo = "R4"; end
                2'b10: begin e_sdo = sdi_pin;   t_sdo = "R5"; end
                default: begin e_sdo = 1'b1;    t_sdo = "R6"; end
            endcase
            if (!rxen) begin
                e_rx = 1'b1; t_rx = "R7";
            end else if (m == 2'b11) begin
                e_rx = tx_serial; t_rx = "R6";
            end else begin
                e_rx = sdi_pin; t_rx = "R3";
            end
            check(t_sdo, $sformatf("sdo_pin word=%h c=%0d%s", v, c, sfx), sdo_pin, e_sdo);
            check(t_rx,  $sformatf("rx_serial word=%h c=%0d%s", v, c, sfx), rx_serial, e_rx);
            check("R5",  $sformatf("tx_run word=%h%s", v, sfx), tx_run, (m != 2'b10));
            check("R8",  $sformatf("rts_n word=%h%s", v, sfx), rts_n, ~v[3]);
            check("R8",  $sformatf("dtr_n word=%h%s", v, sfx), dtr_n, ~v[4]);
            check("R9",  $sformatf("irq_en word=%h%s", v, sfx), irq_en, v[5]);
            check("R9",  $sformatf("modem_irq_en word=%h%s", v, sfx), modem_irq_en, v[6]);
            #1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        sdi_pin = 1'b1; tx_serial = 1'b0;
        #2;
        check("R1", "sdo_pin follows tx (normal)", sdo_pin, 1'b0);
        check("R1", "rx_serial idle (gated)", rx_serial, 1'b1);
        check("R1", "rts_n", rts_n, 1'b1);
        check("R1", "dtr_n", dtr_n, 1'b1);
        check("R1", "irq_en", irq_en, 1'b0);
        check("R1", "modem_irq_en", modem_irq_en, 1'b0);
        check("R1", "tx_run", tx_run, 1'b1);
        tx_serial = 1'b1;
        #2;
        check("R1", "sdo_pin follows tx high", sdo_pin, 1'b1);

        // R2: a write lands exactly at the sampling edge
        @(negedge clk);
        tx_serial = 1'b1;
        wr_en     = 1'b1;
        wr_data   = 8'h09;
        #5;
        check("R2", "sdo_pin before write edge", sdo_pin, 1'b1);
        check("R2", "rts_n before write edge", rts_n, 1'b1);
        @(posedge clk);
        #2;
        check("R2", "sdo_pin after write edge", sdo_pin, 1'b0);
        check("R2", "rts_n after write edge", rts_n, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;

        // Full sweep of all control words, reserved bit included (R10)
        for (int v = 0; v < 256; v++) begin
            write_ctrl(v[7:0]);
            check_word(v[7:0]);
        end

        // R10: reserved bit set versus clear gives the same outputs
        write_ctrl(8'hEE);
        check_word(8'hEE);
        write_ctrl(8'h6E);
        check_word(8'h6E);

        // R11: no strobe, garbage on the bus, word must hold
        write_ctrl(8'h7B);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            wr_data = 8'h84 ^ 8'(k * 37);
        end
        check("R11", "sdo_pin held in loop", sdo_pin, 1'b1);
        check("R11", "rx_serial held gated", rx_serial, 1'b1);
        check("R11", "rts_n held", rts_n, 1'b0);
        check("R11", "irq_en held", irq_en, 1'b1);
        check_word(8'h7B);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule